// File: doc/BRIEF.md
# Segmented Memory Address Translation Unit

This unit sits between a processor core and its three memory targets: the on-chip data RAM, the on-chip instruction RAM and a large unified memory split into 128 KB segments. It serves two independent access streams at once. A 16-bit data address is steered by region: the lower half of the data space maps straight to data RAM. A 16 KB window above that can be pointed by a data map register at either instruction RAM or a slice of a unified segment. The top quarter is an I/O region in which only one 16-byte block is legal.

An 18-bit fetch address picks one of two instruction map registers by its top bit. The chosen map either sends the fetch to instruction RAM unchanged or to a unified segment, in which case the address is cut to 17 bits. A presence bitmap supplied by the surrounding system marks which unified segments exist, and a fetch to an absent segment is flagged as a fault.

The three map registers are loaded through a simple write port. A strap input chooses between two sets of reset values. Each stream's result (target select, physical address, fault) is registered and appears one cycle after the address is presented.

Top module: `seg_xlate`

## Requirements
- R1: A data address with bit 15 clear gives, one cycle later, d_sel = 0 (data RAM), d_phys equal to the address zero-extended, and d_fault = 0.
- R2: A data address at or above 0xC000 gives d_sel = 3 (I/O) and d_phys equal to the address. d_fault is 0 only for 0xFF00 through 0xFF0F and is 1 for every other address in this region. d_fault is never 1 with any other d_sel.
- R3: A data address from 0x8000 to 0xBFFF with data map bit 12 set gives d_sel = 1 (instruction RAM), with d_phys = map[3:0] * 0x4000 + (address - 0x8000), and no fault.
- R4: A data address from 0x8000 to 0xBFFF with data map bit 12 clear gives d_sel = 2 (unified), with d_phys = map[9:3] * 0x20000 + map[2:0] * 0x4000 + (address - 0x8000), and no fault. The segment number occupies d_phys bits 24:17.
- R5: A fetch address uses instruction map 1 when its bit 17 is set and instruction map 0 otherwise. If that map has bit 12 set, the result is f_sel = 1 with f_phys equal to the fetch address, and f_fault = 0.
- R6: If the selected instruction map has bit 12 clear, the result is f_sel = 2 with f_phys = map[7:0] * 0x20000 + fetch address[16:0]. f_fault is set exactly when seg_present[map[7:0]] is 0.
- R7: Reset with rst_alt_maps = 0 loads instruction maps 0 and 1 with 0x1000 and the data map with 0. Reset with rst_alt_maps = 1 loads instruction map 0 with 0, instruction map 1 with 0x007F and the data map with 0.
- R8: A write with map_wr_en = 1 loads map_wr_data into instruction map 0, instruction map 1 or the data map for map_wr_sel = 0, 1 or 2. Code 3 changes nothing. A write affects only addresses presented in later cycles; an address presented in the same cycle as the write is translated with the old value.
- R9: Results are registered: the outputs reflect the addresses of the previous cycle. While rst_n is low (synchronous, active low), all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_alt_maps | input | 1 | Chooses the alternate reset values of the maps |
| map_wr_en | input | 1 | Map register write strobe |
| map_wr_sel | input | 2 | Map selector: 0 instr map 0, 1 instr map 1, 2 data map, 3 none |
| map_wr_data | input | 16 | Value to load into the selected map |
| seg_present | input | 256 | One bit per unified segment, 1 = segment exists |
| d_addr | input | 16 | Logical data address |
| f_addr | input | 18 | Instruction fetch address |
| d_sel | output | 2 | Data target: 0 data RAM, 1 instr RAM, 2 unified, 3 I/O |
| d_phys | output | 25 | Physical data address within the target |
| d_fault | output | 1 | Data bus fault |
| f_sel | output | 2 | Fetch target: 1 instr RAM, 2 unified |
| f_phys | output | 25 | Physical fetch address within the target |
| f_fault | output | 1 | Fetch to an absent unified segment |

## Verification
Data addresses are drawn from all three regions, with extra weight on the legal I/O block and on the edges 0x7FFF, 0x8000, 0xBFFF, 0xC000, 0xFEFF, 0xFF0F and 0xFF10. These separate the region decode from the fault decode. The data map is toggled between its two window modes with distinct page and segment fields, so that a wrong field slice shows up in the physical address. Fetches cover both map selections and both targets, with the presence bitmap driven per segment, and a write is issued in the same cycle as an access through the map it changes to catch early forwarding. Both reset modes are entered and then observed through fetches and window accesses.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int DAW      = 16;                 // data address width
    localparam int FAW      = 18;                 // fetch address width
    localparam int MAP_W    = 16;                 // map register width
    localparam int SEG_W    = 8;                  // unified segment number width
    localparam int UOFF_W   = 17;                 // offset inside one unified segment
    localparam int WIN_W    = 14;                 // offset inside the 16 KB data window
    localparam int PHYS_W   = SEG_W + UOFF_W;     // physical address width
    localparam int NSEG     = 1 << SEG_W;         // unified segment count
    localparam int IPAGE_W  = FAW - WIN_W;        // window page field toward instr RAM
    localparam int UPAGE_W  = PHYS_W - 1 - WIN_W; // window segment+page field toward unified
    localparam int TGT_BIT  = 12;                 // map bit choosing instr RAM
    localparam int IO_TAG_W = DAW - 4;
    localparam logic [IO_TAG_W-1:0] IO_OK_TAG = 12'hFF0;

    typedef enum logic [1:0] {
        TGT_DRAM = 2'd0,
        TGT_IRAM = 2'd1,
        TGT_UNI  = 2'd2,
        TGT_IO   = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [PHYS_W-1:0] phys;
        logic              fault;
    } xlat_t;

    typedef struct packed {
        logic [MAP_W-1:0] imap0;
        logic [MAP_W-1:0] imap1;
        logic [MAP_W-1:0] dmap;
    } maps_t;

    localparam maps_t MAPS_RST_STD = '{imap0: 16'h1000, imap1: 16'h1000, dmap: 16'h0000};
    localparam maps_t MAPS_RST_ALT = '{imap0: 16'h0000, imap1: 16'h007F, dmap: 16'h0000};

endpackage

// File: rtl/seg_xlate_maps.sv
module seg_xlate_maps
    import seg_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_alt_maps,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [MAP_W-1:0] wr_data,
    output logic [MAP_W-1:0] imap0,
    output logic [MAP_W-1:0] imap1,
    output logic [MAP_W-1:0] dmap
);

    maps_t maps_d, maps_q;

    always_comb begin
        maps_d = maps_q;
        if (!rst_n) begin
            maps_d = rst_alt_maps ? MAPS_RST_ALT : MAPS_RST_STD;
        end else if (wr_en) begin
            unique case (wr_sel)
                2'd0:    maps_d.imap0 = wr_data;
                2'd1:    maps_d.imap1 = wr_data;
                2'd2:    maps_d.dmap  = wr_data;
                default: maps_d       = maps_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        maps_q <= maps_d;
    end

    assign imap0 = maps_q.imap0;
    assign imap1 = maps_q.imap1;
    assign dmap  = maps_q.dmap;

endmodule

// File: rtl/seg_xlate_data.sv
module seg_xlate_data
    import seg_xlate_pkg::*;
(
    input  logic [DAW-1:0]   addr,
    input  logic [MAP_W-1:0] dmap,
    output xlat_t            res
);

    logic unused_dmap_bits;
    assign unused_dmap_bits = ^{dmap[MAP_W-1:TGT_BIT+1], dmap[TGT_BIT-1:UPAGE_W]};

    always_comb begin
        res = '{tgt: TGT_DRAM, phys: '0, fault: 1'b0};
        unique case (addr[DAW-1 -: 2])
            2'b00, 2'b01: begin
                res.tgt  = TGT_DRAM;
                res.phys = PHYS_W'(addr);
            end
            2'b10: begin
                if (dmap[TGT_BIT]) begin
                    res.tgt  = TGT_IRAM;
                    res.phys = PHYS_W'({dmap[IPAGE_W-1:0], addr[WIN_W-1:0]});
                end else begin
                    res.tgt  = TGT_UNI;
                    res.phys = PHYS_W'({dmap[UPAGE_W-1:0], addr[WIN_W-1:0]});
                end
            end
            default: begin
                res.tgt   = TGT_IO;
                res.phys  = PHYS_W'(addr);
                res.fault = (addr[DAW-1:4] != IO_OK_TAG);
            end
        endcase
    end

endmodule

// File: rtl/seg_xlate_fetch.sv
module seg_xlate_fetch
    import seg_xlate_pkg::*;
(
    input  logic [FAW-1:0]   addr,
    input  logic [MAP_W-1:0] imap0,
    input  logic [MAP_W-1:0] imap1,
    input  logic [NSEG-1:0]  seg_present,
    output xlat_t            res
);

    logic [MAP_W-1:0] map_sel;
    logic [SEG_W-1:0] seg;
    logic             unused_map_bits;

    assign map_sel = addr[FAW-1] ? imap1 : imap0;
    assign seg     = map_sel[SEG_W-1:0];
    assign unused_map_bits = ^{map_sel[MAP_W-1:TGT_BIT+1], map_sel[TGT_BIT-1:SEG_W]};

    always_comb begin
        res = '{tgt: TGT_IRAM, phys: '0, fault: 1'b0};
        if (map_sel[TGT_BIT]) begin
            res.tgt  = TGT_IRAM;
            res.phys = PHYS_W'(addr);
        end else begin
            res.tgt   = TGT_UNI;
            res.phys  = {seg, addr[UOFF_W-1:0]};
            res.fault = ~seg_present[seg];
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_alt_maps,
    input  logic              map_wr_en,
    input  logic [1:0]        map_wr_sel,
    input  logic [MAP_W-1:0]  map_wr_data,
    input  logic [NSEG-1:0]   seg_present,
    input  logic [DAW-1:0]    d_addr,
    input  logic [FAW-1:0]    f_addr,
    output logic [1:0]        d_sel,
    output logic [PHYS_W-1:0] d_phys,
    output logic              d_fault,
    output logic [1:0]        f_sel,
    output logic [PHYS_W-1:0] f_phys,
    output logic              f_fault
);

    typedef struct packed {
        xlat_t d;
        xlat_t f;
    } out_t;

    logic [MAP_W-1:0] imap0, imap1, dmap;
    xlat_t            d_res, f_res;
    out_t             out_d, out_q;

    seg_xlate_maps u_maps (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_alt_maps (rst_alt_maps),
        .wr_en        (map_wr_en),
        .wr_sel       (map_wr_sel),
        .wr_data      (map_wr_data),
        .imap0        (imap0),
        .imap1        (imap1),
        .dmap         (dmap)
    );

    seg_xlate_data u_data (
        .addr (d_addr),
        .dmap (dmap),
        .res  (d_res)
    );

    seg_xlate_fetch u_fetch (
        .addr        (f_addr),
        .imap0       (imap0),
        .imap1       (imap1),
        .seg_present (seg_present),
        .res         (f_res)
    );

    always_comb begin
        out_d = out_q;
        if (!rst_n) begin
            out_d = '0;
        end else begin
            out_d.d = d_res;
            out_d.f = f_res;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign d_sel   = out_q.d.tgt;
    assign d_phys  = out_q.d.phys;
    assign d_fault = out_q.d.fault;
    assign f_sel   = out_q.f.tgt;
    assign f_phys  = out_q.f.phys;
    assign f_fault = out_q.f.fault;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              map_wr_en,
    input logic [DAW-1:0]    d_addr,
    input logic [FAW-1:0]    f_addr,
    input logic [1:0]        d_sel,
    input logic [PHYS_W-1:0] d_phys,
    input logic              d_fault,
    input logic [1:0]        f_sel,
    input logic              f_fault,
    input logic [MAP_W-1:0]  imap0,
    input logic [MAP_W-1:0]  imap1,
    input logic [MAP_W-1:0]  dmap
);

    AST_LOW_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (d_addr[DAW-1] == 1'b0) |=> (d_sel == 2'd0 && !d_fault && d_phys == PHYS_W'($past(d_addr)))); // R1

    AST_IO_BAD_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (d_addr[DAW-1 -: 2] == 2'b11 && d_addr[DAW-1:4] != IO_OK_TAG) |=> (d_fault && d_sel == 2'd3)); // R2

    AST_FAULT_ONLY_IO: assert property (@(posedge clk) disable iff (!rst_n)
        d_fault |-> (d_sel == 2'd3)); // R2

    AST_WIN_TO_IRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (d_addr[DAW-1 -: 2] == 2'b10 && dmap[TGT_BIT])
        |=> (d_sel == 2'd1 && !d_fault
             && d_phys == PHYS_W'({$past(dmap[IPAGE_W-1:0]), $past(d_addr[WIN_W-1:0])}))); // R3

    AST_FETCH_IRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (f_addr[FAW-1] ? imap1[TGT_BIT] : imap0[TGT_BIT]) |=> (f_sel == 2'd1 && !f_fault)); // R5

    AST_FETCH_FAULT_UNI: assert property (@(posedge clk) disable iff (!rst_n)
        f_fault |-> (f_sel == 2'd2)); // R6

    AST_MAPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !map_wr_en |=> ($stable(imap0) && $stable(imap1) && $stable(dmap))); // R8

endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .map_wr_en (map_wr_en),
    .d_addr    (d_addr),
    .f_addr    (f_addr),
    .d_sel     (d_sel),
    .d_phys    (d_phys),
    .d_fault   (d_fault),
    .f_sel     (f_sel),
    .f_fault   (f_fault),
    .imap0     (imap0),
    .imap1     (imap1),
    .dmap      (dmap)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rst_alt_maps = 1'b0;
    logic          map_wr_en = 1'b0;
    logic [1:0]    map_wr_sel = 2'd0;
    logic [15:0]   map_wr_data = 16'd0;
    logic [255:0]  seg_present = '0;
    logic [15:0]   d_addr = 16'd0;
    logic [17:0]   f_addr = 18'd0;
    logic [1:0]    d_sel, f_sel;
    logic [24:0]   d_phys, f_phys;
    logic          d_fault, f_fault;

    int total = 0;
    int bad = 0;
    logic [15:0] m_imap0, m_imap1, m_dmap;

    always #2 clk = ~clk;

    seg_xlate u_dut (
        .clk (clk), .rst_n (rst_n), .rst_alt_maps (rst_alt_maps),
        .map_wr_en (map_wr_en), .map_wr_sel (map_wr_sel), .map_wr_data (map_wr_data),
        .seg_present (seg_present), .d_addr (d_addr), .f_addr (f_addr),
        .d_sel (d_sel), .d_phys (d_phys), .d_fault (d_fault),
        .f_sel (f_sel), .f_phys (f_phys), .f_fault (f_fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {sel, fault, phys}
    function automatic logic [27:0] exp_data(input logic [15:0] a, input logic [15:0] dm);
        logic [24:0] p;
        logic [1:0]  s;
        logic        f;
        f = 1'b0;
        if (a < 16'h8000) begin
            s = 2'd0; p = 25'(a);
        end else if (a < 16'hC000) begin
            if (dm[12]) begin
                s = 2'd1;
                p = 25'(dm[3:0]) * 25'h4000 + 25'(a - 16'h8000);
            end else begin
                s = 2'd2;
                p = 25'(dm[9:3]) * 25'h20000 + 25'(dm[2:0]) * 25'h4000 + 25'(a - 16'h8000);
            end
        end else begin
            s = 2'd3; p = 25'(a);
            f = !(a >= 16'hFF00 && a <= 16'hFF0F);
        end
        return {s, f, p};
    endfunction

    function automatic logic [27:0] exp_fetch(input logic [17:0] a, input logic [15:0] i0,
                                              input logic [15:0] i1, input logic [255:0] pres);
        logic [15:0] m;
        m = (a >= 18'h20000) ? i1 : i0;
        if (m[12]) return {2'd1, 1'b0, 25'(a)};
        return {2'd2, !pres[m[7:0]], 25'(m[7:0]) * 25'h20000 + 25'(a % 18'h20000)};
    endfunction

    function automatic string data_tag(input logic [15:0] a, input logic [15:0] dm);
        if (a < 16'h8000) return "R1";
        if (a >= 16'hC000) return "R2";
        return dm[12] ? "R3" : "R4";
    endfunction

    function automatic string fetch_tag(input logic [17:0] a, input logic [15:0] i0, input logic [15:0] i1);
        logic [15:0] m;
        m = (a >= 18'h20000) ? i1 : i0;
        return m[12] ? "R5" : "R6";
    endfunction

    // Called just after a falling edge: drive, then compare one cycle later (R9 latency)
    task automatic run_cycle(input logic [15:0] da, input logic [17:0] fa, input logic we,
                             input logic [1:0] ws, input logic [15:0] wd, input string note);
        logic [27:0] ed, ef;
        string td, tf;
        d_addr = da; f_addr = fa;
        map_wr_en = we; map_wr_sel = ws; map_wr_data = wd;
        ed = exp_data(da, m_dmap);
        ef = exp_fetch(fa, m_imap0, m_imap1, seg_present);
        td = data_tag(da, m_dmap);
        tf = fetch_tag(fa, m_imap0, m_imap1);
        if (we) begin
            case (ws)
                2'd0: m_imap0 = wd;
                2'd1: m_imap1 = wd;
                2'd2: m_dmap  = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        map_wr_en = 1'b0;
        check({td, " data ", note}, {4'd0, d_sel, d_fault, d_phys}, {4'd0, ed});
        check({tf, " fetch ", note}, {4'd0, f_sel, f_fault, f_phys}, {4'd0, ef});
    endtask

    task automatic do_reset(input logic alt);
        rst_n = 1'b0; rst_alt_maps = alt;
        d_addr = 16'hFFFF; f_addr = 18'h3FFFF; map_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 reset outputs", {2'd0, d_sel, d_fault, d_phys}, 30'd0);
        check("R9 reset outputs", {2'd0, f_sel, f_fault, f_phys}, 30'd0);
        rst_n = 1'b1;
        if (alt) begin m_imap0 = 16'h0000; m_imap1 = 16'h007F; end
        else     begin m_imap0 = 16'h1000; m_imap1 = 16'h1000; end
        m_dmap = 16'h0000;
    endtask

    function automatic logic [15:0] rand_daddr();
        case ($urandom % 6)
            0, 1:    return {1'b0, 15'($urandom)};
            2, 3:    return 16'h8000 | 16'($urandom % 16'h4000);
            4:       return 16'hFF00 | 16'($urandom % 16);
            default: return 16'hC000 | 16'($urandom % 16'h4000);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < 8; i++) seg_present[i*32 +: 32] = $urandom;
        seg_present[8'h42] = 1'b0;
        seg_present[8'h43] = 1'b1;
        seg_present[8'h00] = 1'b1;
        seg_present[8'h7F] = 1'b0;
        @(negedge clk);

        // R7 standard reset values, seen through fetch and window accesses
        do_reset(1'b0);
        run_cycle(16'h1234, 18'h00100, 1'b0, 2'd0, 16'h0, "R7 std");
        run_cycle(16'h9000, 18'h20004, 1'b0, 2'd0, 16'h0, "R7 std");
        // R1 / R2 boundaries
        run_cycle(16'h7FFF, 18'h1FFFF, 1'b0, 2'd0, 16'h0, "R1 edge");
        run_cycle(16'hFF00, 18'h0, 1'b0, 2'd0, 16'h0, "R2 first legal");
        run_cycle(16'hFF0F, 18'h0, 1'b0, 2'd0, 16'h0, "R2 last legal");
        run_cycle(16'hFF10, 18'h0, 1'b0, 2'd0, 16'h0, "R2 above block");
        run_cycle(16'hFEFF, 18'h0, 1'b0, 2'd0, 16'h0, "R2 below block");
        run_cycle(16'hC000, 18'h0, 1'b0, 2'd0, 16'h0, "R2 region start");
        run_cycle(16'hFFFF, 18'h0, 1'b0, 2'd0, 16'h0, "R2 region end");
        // R8 write takes effect one cycle late, R3 window to instr RAM
        run_cycle(16'h8004, 18'h0, 1'b1, 2'd2, 16'h1005, "R8 same cycle old map");
        run_cycle(16'h8004, 18'h0, 1'b0, 2'd0, 16'h0, "R8 new map");
        run_cycle(16'hBFFF, 18'h0, 1'b0, 2'd0, 16'h0, "R3 window end");
        // R4 unified window with all segment/page bits set
        run_cycle(16'h8000, 18'h0, 1'b1, 2'd2, 16'h03FF, "R4 load");
        run_cycle(16'h8000, 18'h0, 1'b0, 2'd0, 16'h0, "R4 window start");
        run_cycle(16'hA5A5, 18'h0, 1'b0, 2'd0, 16'h0, "R4 mid");
        // R8 selector code 3 changes nothing
        run_cycle(16'h8010, 18'h0, 1'b1, 2'd3, 16'hFFFF, "R8 code 3");
        run_cycle(16'h8010, 18'h20010, 1'b0, 2'd0, 16'h0, "R8 code 3 no effect");
        // R6 absent and present segments, R5 map 1 selection
        run_cycle(16'h0, 18'h0, 1'b1, 2'd0, 16'h0042, "R6 load");
        run_cycle(16'h0, 18'h1ABCD, 1'b1, 2'd1, 16'h0043, "R6 absent seg");
        run_cycle(16'h0, 18'h3FFFF, 1'b0, 2'd0, 16'h0, "R6 present seg truncated");
        run_cycle(16'h0, 18'h00007, 1'b1, 2'd1, 16'h1000, "R6 map0 still unified");
        run_cycle(16'h0, 18'h2FFFF, 1'b0, 2'd0, 16'h0, "R5 map1 instr RAM");

        // R7 alternate reset values
        do_reset(1'b1);
        run_cycle(16'h8123, 18'h01234, 1'b0, 2'd0, 16'h0, "R7 alt");
        run_cycle(16'h4000, 18'h21234, 1'b0, 2'd0, 16'h0, "R7 alt");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic        we;
            logic [15:0] wd;
            we = ($urandom % 4) == 0;
            wd = 16'($urandom);
            if (($urandom % 2) == 0) wd[12] = 1'b0;
            if (($urandom % 16) == 0) begin
                int idx;
                idx = int'($urandom % 256);
                seg_present[idx] = ~seg_present[idx];
            end
            run_cycle(rand_daddr(), 18'($urandom), we, 2'($urandom), wd, "random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule